// File: doc/BRIEF.md
# Biphase Rail Packet Transmitter

This block sends short data packets over one rail-power line that also feeds the loads on the rail. Each bit takes two half-bit periods: the rail first carries the bit's true value and then its complement, so the line has no long run at one level and the mean power stays steady. Between packets the rail is held high, and the loads draw their supply from it.

Packets are launched on a fixed count of system ticks. Each launch starts from the highest bit index and counts down to index 0. The word being sent is double-buffered. Software places the next word and its length in a one-entry queue, and the queue moves into the active slot only when a packet finishes. At the same moment the queued word is cleared, and the block raises a one-cycle done strobe that starts a separate response receiver.

The block takes a half-bit tick (one pulse per 50 µs at system level) and a system tick (one pulse per 500 µs). With the defaults a packet launches every 15 system ticks, which is 7.5 ms. The rail level is registered, so it changes in the clock cycle after the tick that causes the change.

Top module: `biphase_rail_tx`

## Requirements
- R1: After reset, `rail_out` is 1 and `tx_done` is 0. The block is idle. The active word is 0 and the staged length is 0.
- R2: While idle, `rail_out` stays 1, and half-bit ticks cause no rail change and no `tx_done`.
- R3: The block counts system ticks from reset. Every `LAUNCH_TICKS`-th tick (default 15) launches a packet. The launch loads the bit index from the staged length and selects the first half of the bit. A launch does not change the rail itself.
- R4: In an active bit, the first half-bit tick drives `rail_out` to the bit's value. The second half-bit tick drives its complement.
- R5: Bits go out from index = staged length down to index 0, most significant first. Bit i of the word is `word[i]`.
- R6: The half-bit tick after the second half of bit 0 drives `rail_out` to 1 and returns the block to idle. `tx_done` is 1 for exactly that one cycle.
- R7: At the end of a packet, the queued word becomes the active word and the queued length becomes the staged length. The queued word is then cleared to 0, so a later packet with no new write sends all zeros. The queued length is kept.
- R8: A queue write during a packet does not change the bits of that packet.
- R9: A queued length above `DATA_W-1` is saturated to `DATA_W-1`, which is 15 by default.
- R10: When a system tick completes a launch count in the same cycle as a half-bit tick, the launch wins. The packet restarts from its top bit, the rail keeps its level, and no `tx_done` occurs. With no tick, the rail keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | One-cycle pulse per half-bit period |
| sys_tick | input | 1 | One-cycle pulse per system tick |
| q_wr | input | 1 | Write strobe for the queue entry |
| q_data | input | DATA_W | Word for the next packet |
| q_len | input | 7 | Top bit index for the next packet |
| rail_out | output | 1 | Registered rail-power drive, 1 = powered |
| tx_done | output | 1 | One-cycle strobe at packet end |

## Verification
The assertions check four properties on every cycle:
- the rail is high whenever the block is idle;
- the second half of a bit always flips the rail;
- the done strobe lasts one cycle and comes only from the terminal state;
- the active buffer changes only at a packet end, and the staged length never exceeds `DATA_W-1`.

Only the bench scenarios can show the parts that depend on the data itself. These are:
- the most-significant-first order of real words;
- the timing of the 15-tick launch;
- the word hand-over from the queue, and the zero word sent after the queue is drained;
- length saturation;
- the restart of a packet when a launch lands on a half-bit tick.

// File: rtl/biphase_pkg.sv
package biphase_pkg;

    // Width of the bit index; the serializer state is {hi, idx}.
    localparam int unsigned IDX_W = 7;

    typedef struct packed {
        logic             hi;   // 1 = second (complement) half
        logic [IDX_W-1:0] idx;  // bit being sent
    } tx_state_t;

    // Reserved encodings that no active bit can reach (idx <= DATA_W-1).
    localparam tx_state_t ST_IDLE = tx_state_t'({1'b1, {IDX_W{1'b1}}});
    localparam tx_state_t ST_TERM = tx_state_t'({1'b1, {(IDX_W-1){1'b1}}, 1'b0});

endpackage

// File: rtl/biphase_launch_timer.sv
module biphase_launch_timer #(
    parameter int unsigned LAUNCH_TICKS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_tick,
    output logic launch
);
    localparam int unsigned CW = (LAUNCH_TICKS > 2) ? $clog2(LAUNCH_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(LAUNCH_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        launch = 1'b0;
        if (sys_tick) begin
            if (tmr_q.cnt == LAST) begin
                launch    = 1'b1;
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R3: the tick counter never passes the launch count
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST);

    // R3: a sys tick that does not launch advances the count by one
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_tick && !launch) |=> (tmr_q.cnt == $past(tmr_q.cnt) + 1'b1));

endmodule

// File: rtl/biphase_queue.sv
module biphase_queue
    import biphase_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  wr_len,
    input  logic              consume,
    output logic [DATA_W-1:0] act_word,
    output logic [IDX_W-1:0]  act_len
);
    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] q_word;
        logic [IDX_W-1:0]  q_len;
        logic [DATA_W-1:0] a_word;
        logic [IDX_W-1:0]  a_len;
    } qbuf_t;

    qbuf_t qb_d, qb_q;
    logic [IDX_W-1:0] sat_len;

    always_comb begin
        sat_len = (wr_len > MAX_IDX) ? MAX_IDX : wr_len;
        qb_d    = qb_q;
        if (consume) begin
            qb_d.a_word = qb_q.q_word;
            qb_d.a_len  = qb_q.q_len;
            qb_d.q_word = '0;
        end
        // A write in the same cycle as a hand-over refills the queue.
        if (wr_en) begin
            qb_d.q_word = wr_data;
            qb_d.q_len  = sat_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) qb_q <= '0;
        else        qb_q <= qb_d;
    end

    assign act_word = qb_q.a_word;
    assign act_len  = qb_q.a_len;

    // R8: the word on the rail only changes at a packet end
    p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !consume |=> ($stable(act_word) && $stable(act_len)));

    // R9: the staged length always addresses a real bit
    p_len_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        act_len <= MAX_IDX);

endmodule

// File: rtl/biphase_serializer.sv
module biphase_serializer
    import biphase_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              launch,
    input  logic [DATA_W-1:0] word,
    input  logic [IDX_W-1:0]  len,
    output logic              rail,
    output logic              done,
    output logic              consume
);
    typedef struct packed {
        tx_state_t st;
        logic      rail;
        logic      done;
    } ser_t;

    ser_t ser_d, ser_q;
    logic [DATA_W-1:0] shifted;
    logic              cur_bit;
    logic              active;

    always_comb begin
        shifted = word >> ser_q.st.idx;
        cur_bit = shifted[0];
        active  = (ser_q.st != ST_IDLE) && (ser_q.st != ST_TERM);
        ser_d      = ser_q;
        ser_d.done = 1'b0;
        consume    = 1'b0;
        if (launch) begin
            ser_d.st.hi  = 1'b0;
            ser_d.st.idx = len;
        end else if (half_tick) begin
            if (ser_q.st == ST_TERM) begin
                ser_d.rail = 1'b1;
                ser_d.st   = ST_IDLE;
                ser_d.done = 1'b1;
                consume    = 1'b1;
            end else if (active) begin
                ser_d.rail = ser_q.st.hi ? ~cur_bit : cur_bit;
                if (!ser_q.st.hi) begin
                    ser_d.st.hi = 1'b1;
                end else if (ser_q.st.idx == '0) begin
                    ser_d.st = ST_TERM;
                end else begin
                    ser_d.st.hi  = 1'b0;
                    ser_d.st.idx = ser_q.st.idx - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_q.st   <= ST_IDLE;
            ser_q.rail <= 1'b1;
            ser_q.done <= 1'b0;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign rail = ser_q.rail;
    assign done = ser_q.done;

    // R2: an idle rail carries power
    p_idle_rail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_q.st == ST_IDLE) |-> ser_q.rail);

    // R4: the second half of a bit always flips the rail
    p_complement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (half_tick && !launch && active && ser_q.st.hi) |=> (ser_q.rail != $past(ser_q.rail)));

    // R6: the done strobe lasts one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_q.done |=> !ser_q.done);

    // R6: done only follows the terminal state
    p_done_from_term_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_q.done |-> $past(ser_q.st == ST_TERM));

    // R10: a launch restarts without touching the rail or ending the packet
    p_launch_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (!ser_q.done && $stable(ser_q.rail)));

    // R10: with no half-bit tick the rail holds
    p_rail_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> $stable(ser_q.rail));

endmodule

// File: rtl/biphase_rail_tx.sv
module biphase_rail_tx
    import biphase_pkg::*;
#(
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned LAUNCH_TICKS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              sys_tick,
    input  logic              q_wr,
    input  logic [DATA_W-1:0] q_data,
    input  logic [IDX_W-1:0]  q_len,
    output logic              rail_out,
    output logic              tx_done
);
    logic              launch;
    logic              consume;
    logic [DATA_W-1:0] act_word;
    logic [IDX_W-1:0]  act_len;

    initial begin
        if (DATA_W + 2 > (1 << IDX_W))
            $error("DATA_W collides with the reserved state encodings");
    end

    biphase_launch_timer #(
        .LAUNCH_TICKS(LAUNCH_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sys_tick(sys_tick),
        .launch  (launch)
    );

    biphase_queue #(
        .DATA_W(DATA_W)
    ) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (q_wr),
        .wr_data (q_data),
        .wr_len  (q_len),
        .consume (consume),
        .act_word(act_word),
        .act_len (act_len)
    );

    biphase_serializer #(
        .DATA_W(DATA_W)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_tick(half_tick),
        .launch   (launch),
        .word     (act_word),
        .len      (act_len),
        .rail     (rail_out),
        .done     (tx_done),
        .consume  (consume)
    );

endmodule

// File: tb/biphase_rail_tx_tb.sv
module biphase_rail_tx_tb;

    typedef struct packed {
        logic [15:0] d;
        logic [6:0]  l;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{16'hA5C3, 7'd15},
        '{16'h0001, 7'd0},
        '{16'h8000, 7'd15},
        '{16'h00F0, 7'd7},
        '{16'hFFFF, 7'd40},   // R9: saturates to 15
        '{16'h1234, 7'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_tick = 1'b0;
    logic        sys_tick = 1'b0;
    logic        q_wr = 1'b0;
    logic [15:0] q_data = '0;
    logic [6:0]  q_len = '0;
    logic        rail_out;
    logic        tx_done;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    biphase_rail_tx u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_tick(half_tick),
        .sys_tick (sys_tick),
        .q_wr     (q_wr),
        .q_data   (q_data),
        .q_len    (q_len),
        .rail_out (rail_out),
        .tx_done  (tx_done)
    );

    function automatic int eff_len(input logic [6:0] l);
        return (l > 7'd15) ? 15 : int'(l);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input logic h, input logic s);
        @(negedge clk);
        half_tick = h;
        sys_tick  = s;
        @(negedge clk);
        half_tick = 1'b0;
        sys_tick  = 1'b0;
    endtask

    task automatic qwrite(input logic [15:0] d, input logic [6:0] l);
        @(negedge clk);
        q_wr = 1'b1; q_data = d; q_len = l;
        @(negedge clk);
        q_wr = 1'b0;
    endtask

    // R3: fifteen sys ticks; the rail is untouched throughout
    task automatic do_launch(input logic lvl);
        for (int i = 0; i < 15; i++) begin
            tick(1'b0, 1'b1);
            chk(rail_out == lvl, "R3 rail during launch count", rail_out, lvl);
        end
    endtask

    // R4/R5/R8: send bits top..0, optionally writing the queue after the first bit
    task automatic send_bits(input logic [15:0] d, input int top,
                             input bit wr, input logic [15:0] nd, input logic [6:0] nl);
        for (int i = top; i >= 0; i--) begin
            tick(1'b1, 1'b0);
            chk(rail_out == d[i], "R4 R5 first half", rail_out, d[i]);
            if (wr && i == top) qwrite(nd, nl);   // R8
            tick(1'b1, 1'b0);
            chk(rail_out == ~d[i], "R4 second half", rail_out, ~d[i]);
        end
    endtask

    // R6: terminal tick then idle; R2 idle ticks ignored
    task automatic finish_pkt();
        tick(1'b1, 1'b0);
        chk(rail_out == 1'b1, "R6 rail high at end", rail_out, 1);
        chk(tx_done == 1'b1, "R6 done strobe", tx_done, 1);
        @(negedge clk);
        chk(tx_done == 1'b0, "R6 done one cycle", tx_done, 0);
        tick(1'b1, 1'b0);
        chk(rail_out == 1'b1 && tx_done == 1'b0, "R2 idle tick ignored", rail_out, 1);
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog R1..R10 actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(rail_out == 1'b1, "R1 reset rail", rail_out, 1);
        chk(tx_done == 1'b0, "R1 reset done", tx_done, 0);
        // R2: idle ignores half ticks
        for (int i = 0; i < 3; i++) begin
            tick(1'b1, 1'b0);
            chk(rail_out == 1'b1 && tx_done == 1'b0, "R2 idle", rail_out, 1);
        end
        // R1: first packet uses reset word 0 and length 0
        qwrite(VEC[0].d, VEC[0].l);
        do_launch(1'b1);
        send_bits(16'h0000, 0, 1'b0, '0, '0);
        finish_pkt();

        // Table walk: packet k sends VEC[k]; VEC[k+1] is queued mid-packet (R8, R7)
        for (int k = 0; k < NV; k++) begin
            do_launch(1'b1);
            send_bits(VEC[k].d, eff_len(VEC[k].l), (k < NV - 1),
                      VEC[(k < NV - 1) ? k + 1 : k].d, VEC[(k < NV - 1) ? k + 1 : k].l);
            finish_pkt();
        end

        // R7: queue drained, word cleared to zero, length kept; queue Y meanwhile
        do_launch(1'b1);
        send_bits(16'h0000, eff_len(VEC[NV-1].l), 1'b1, 16'h6C39, 7'd11);
        finish_pkt();

        // R10: launch collides with a half tick mid-packet
        do_launch(1'b1);
        tick(1'b1, 1'b0);
        chk(rail_out == 1'b1, "R5 Y bit11 first half", rail_out, 1);
        tick(1'b1, 1'b0);
        chk(rail_out == 1'b0, "R4 Y bit11 second half", rail_out, 0);
        for (int i = 0; i < 14; i++) begin
            tick(1'b0, 1'b1);
            chk(rail_out == 1'b0, "R10 rail holds without tick", rail_out, 0);
        end
        tick(1'b1, 1'b1);
        chk(rail_out == 1'b0, "R10 launch wins rail held", rail_out, 0);
        chk(tx_done == 1'b0, "R10 launch wins no done", tx_done, 0);
        send_bits(16'h6C39, 11, 1'b0, '0, '0);
        finish_pkt();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule